// File: doc/BRIEF.md
# Two-Stage Level-Controlled DAC Code Latch

This block is the digital front end of an 8-bit voltage-output converter. It holds two cascaded code registers: a staging register that captures the parallel data bus, and a converter register whose contents set the output level. Each register has its own active-low enable condition built from the select, write and load strobes. An active-low clear strobe empties both registers. The clear acts as a momentary zero override while the registers are open, and as a lasting clear when they are closed.

The strobes are level-sensitive. The block samples them on a fast system clock. A register reloads on every clock edge while its enable condition holds, so a held enable acts like an open latch, with one clock of delay per stage. The block also produces a 16-bit scaled output: the product of an 8-bit reference code and the converter code. The upper byte of this output is the reference scaled by code/256.

The data bus and the strobes are plain level signals with no handshake. The block has no back-pressure: a value is taken whenever the enable condition is true at a clock edge. For this reason no valid/ready pair appears at the edge of the block.

Top module: `dlc_latch_pair`

## Requirements
- R1: While the system reset `rst_n` is low, `dac_code` and `out_scaled` are zero, and both registers hold zero after it is released.
- R2: On each clock edge where `sel_n`=0, `wr_n`=0 and `clr_n`=1, the staging register takes `din`. `din[7]` is the most significant bit.
- R3: When `sel_n`=1 or `wr_n`=1, the staging register keeps its value, whatever `din` does.
- R4: On each clock edge where `ld_n`=0, `wr_n`=0 and `clr_n`=1, the converter register takes the staging register's value from before that edge.
- R5: When `ld_n`=1 or `wr_n`=1, `dac_code` keeps its value.
- R6: With `sel_n`, `wr_n` and `ld_n` all low and `clr_n` high, `dac_code` equals `din` from two clock edges earlier. The output therefore follows the bus.
- R7: A clock edge with `clr_n`=0 loads zero into both registers, whatever the state of the other strobes.
- R8: If a clear occurs while both registers are closed (`wr_n`=1), `dac_code` stays zero after `clr_n` returns high, until a new write.
- R9: If a clear occurs while all strobes are low, `dac_code` is zero during the clear. Two clock edges after `clr_n` returns high, `dac_code` again equals `din`.
- R10: `out_scaled` equals `ref_code` times `dac_code` as a 16-bit unsigned value. With `ref_code`=0xFF, the codes 0xFF, 0x80, 0x01 and 0x00 give 0xFE01, 0x7F80, 0x00FF and 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sel_n | input | 1 | Active-low chip select for the staging register |
| wr_n | input | 1 | Active-low write strobe, shared by both registers |
| ld_n | input | 1 | Active-low load strobe for the converter register |
| clr_n | input | 1 | Active-low synchronous clear of both registers |
| din | input | 8 | Parallel data bus, bit 7 most significant |
| ref_code | input | 8 | Reference level code used for scaling |
| dac_code | output | 8 | Converter register contents |
| out_scaled | output | 16 | ref_code times dac_code; upper byte is the output in 1/256 steps |

## Verification
The first pattern opens the staging register alone and then the converter register alone while the bus changes. A mix-up between the two enables, or a bypassed stage, shows up here. The second pattern holds all strobes low and steps the bus through several values. This confirms the two-edge follow delay and rules out a single-stage shortcut. The clear is applied once with the registers open and once with them closed. These two cases separate the momentary override from the lasting clear, and they also show that the clear wins over the write enables. Each code in the scaling table is applied at two reference levels, and a reference model compares every clock.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

  localparam int unsigned DLC_CODE_W = 8;
  localparam int unsigned DLC_REF_W  = 8;

  typedef struct packed {
    logic clr;     // clear both stages this edge
    logic stg_en;  // staging register open
    logic cnv_en;  // converter register open
  } dlc_ctl_t;

endpackage

// File: rtl/dlc_ctrl_decode.sv
module dlc_ctrl_decode
  import dlc_pkg::*;
(
  input  logic     sel_n,
  input  logic     wr_n,
  input  logic     ld_n,
  input  logic     clr_n,
  output dlc_ctl_t ctl
);

  logic wr_act;

  always_comb begin
    wr_act     = ~wr_n;
    ctl.clr    = ~clr_n;
    // clear dominates: enables are masked while clear is active (R7)
    ctl.stg_en = wr_act & ~sel_n & clr_n;
    ctl.cnv_en = wr_act & ~ld_n & clr_n;
  end

endmodule

// File: rtl/dlc_stage.sv
module dlc_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= d;
  end

  // R7: a clear edge leaves zero
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  // R2 (staging stage) and R4 (converter stage): open stage captures d
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (q == $past(d)));

  // R3 (staging stage) and R5 (converter stage): closed stage holds
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(q));

endmodule

// File: rtl/dlc_scale.sv
module dlc_scale #(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 8,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic [P_W-1:0] p
);

  logic [P_W-1:0] pp  [B_W];
  logic [P_W-1:0] acc [B_W+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < B_W; i++) begin : g_pp
    assign pp[i]    = b[i] ? ({{B_W{1'b0}}, a} << i) : '0;
    assign acc[i+1] = acc[i] + pp[i];
  end

  assign p = acc[B_W];

endmodule

// File: rtl/dlc_latch_pair.sv
module dlc_latch_pair
  import dlc_pkg::*;
#(
  parameter int unsigned CODE_W = DLC_CODE_W,
  parameter int unsigned REF_W  = DLC_REF_W,
  localparam int unsigned OUT_W = CODE_W + REF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic              clr_n,
  input  logic [CODE_W-1:0] din,
  input  logic [REF_W-1:0]  ref_code,
  output logic [CODE_W-1:0] dac_code,
  output logic [OUT_W-1:0]  out_scaled
);

  dlc_ctl_t          ctl;
  logic [CODE_W-1:0] stg_q;
  logic [CODE_W-1:0] cnv_q;

  dlc_ctrl_decode u_dec (
    .sel_n (sel_n),
    .wr_n  (wr_n),
    .ld_n  (ld_n),
    .clr_n (clr_n),
    .ctl   (ctl)
  );

  dlc_stage #(.W(CODE_W)) u_stg (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.clr),
    .en    (ctl.stg_en),
    .d     (din),
    .q     (stg_q)
  );

  dlc_stage #(.W(CODE_W)) u_cnv (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.clr),
    .en    (ctl.cnv_en),
    .d     (stg_q),
    .q     (cnv_q)
  );

  dlc_scale #(.A_W(REF_W), .B_W(CODE_W)) u_scale (
    .a (ref_code),
    .b (cnv_q),
    .p (out_scaled)
  );

  assign dac_code = cnv_q;

  // ---- checks on port behaviour ----
  logic       all_open;
  logic [1:0] armed;

  assign all_open = !sel_n && !wr_n && !ld_n && clr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             armed <= '0;
    else if (armed != 2'd3) armed <= armed + 2'd1;
  end

  // R1: outputs zero while in system reset
  always_comb begin
    if (!rst_n) begin
      p_reset_zero_r1: assert (dac_code == '0 || $isunknown(dac_code));
    end
  end

  // R6: output follows the bus with two edges of delay
  p_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed == 2'd3 && $past(all_open, 1) && $past(all_open, 2))
      |-> (dac_code == $past(din, 2)));

  // R8: after a clear with write high, zero persists while write stays high
  p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_code == '0 && wr_n) |=> (dac_code == '0));

  // R10: scaled output is the product of reference and code
  p_scale_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_scaled == OUT_W'(ref_code) * OUT_W'(dac_code));

endmodule

// File: tb/dlc_latch_pair_bench.sv
module dlc_latch_pair_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
  logic [7:0] din = 8'h00, ref_code = 8'hFF;
  logic [7:0] dac_code;
  logic [15:0] out_scaled;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  string phase = "R1";

  // reference model state
  int stg_m = 0;
  int cnv_m = 0;

  always #2.5 clk = ~clk;

  dlc_latch_pair u_dlc_latch_pair (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .wr_n       (wr_n),
    .ld_n       (ld_n),
    .clr_n      (clr_n),
    .din        (din),
    .ref_code   (ref_code),
    .dac_code   (dac_code),
    .out_scaled (out_scaled)
  );

  task automatic expect_val(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare at the falling edge
  task automatic step();
    int n_stg;
    int n_cnv;
    @(posedge clk);
    n_stg = stg_m;
    n_cnv = cnv_m;
    if (!rst_n || !clr_n) begin
      n_stg = 0;
      n_cnv = 0;
    end else begin
      if (!sel_n && !wr_n) n_stg = int'(din);
      if (!ld_n && !wr_n)  n_cnv = stg_m;
    end
    stg_m = n_stg;
    cnv_m = n_cnv;
    @(negedge clk);
    expect_val({phase, " model code"}, int'(dac_code), cnv_m);
    expect_val("R10 model scale", int'(out_scaled), cnv_m * int'(ref_code));
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic strobes(logic s, logic w, logic l, logic c);
    sel_n = s; wr_n = w; ld_n = l; clr_n = c;
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: system reset
    phase = "R1";
    strobes(1'b0, 1'b0, 1'b0, 1'b1);
    din = 8'hA5;
    steps(3);
    expect_val("R1 reset code", int'(dac_code), 0);
    @(negedge clk);
    rst_n = 1'b1;
    strobes(1'b1, 1'b1, 1'b1, 1'b1);
    steps(2);
    expect_val("R1 after release", int'(dac_code), 0);

    // R2 / R5: staging only; converter closed
    phase = "R2";
    strobes(1'b0, 1'b0, 1'b1, 1'b1);
    din = 8'h5A;
    steps(3);
    expect_val("R5 converter held", int'(dac_code), 0);

    // R3 / R4: staging closed by select, converter loads staged value
    phase = "R4";
    strobes(1'b1, 1'b0, 1'b0, 1'b1);
    din = 8'h33;
    steps(2);
    expect_val("R4 staged value", int'(dac_code), 8'h5A);
    expect_val("R3 bus ignored", int'(dac_code), 8'h5A);

    // R3 / R5: write high closes both
    phase = "R5";
    strobes(1'b0, 1'b1, 1'b0, 1'b1);
    din = 8'hC3;
    steps(3);
    expect_val("R5 write high holds", int'(dac_code), 8'h5A);

    // R6: all open, output follows the bus
    phase = "R6";
    strobes(1'b0, 1'b0, 1'b0, 1'b1);
    din = 8'hFF;
    steps(2);
    expect_val("R6 follow FF", int'(dac_code), 8'hFF);
    din = 8'h80;
    step();
    expect_val("R6 one edge later", int'(dac_code), 8'hFF);
    step();
    expect_val("R6 follow 80", int'(dac_code), 8'h80);
    for (int v = 1; v < 6; v++) begin
      din = 8'(v * 37);
      step();
    end
    step();
    expect_val("R6 follow sweep", int'(dac_code), (5 * 37) & 8'hFF);

    // R7 / R9: clear while open: momentary override
    phase = "R9";
    din = 8'h6C;
    steps(2);
    clr_n = 1'b0;
    step();
    expect_val("R7 clear wins", int'(dac_code), 0);
    steps(2);
    expect_val("R9 zero during clear", int'(dac_code), 0);
    clr_n = 1'b1;
    step();
    expect_val("R9 first edge after", int'(dac_code), 0);
    step();
    expect_val("R9 follows again", int'(dac_code), 8'h6C);

    // R8: clear while closed persists
    phase = "R8";
    strobes(1'b1, 1'b1, 1'b1, 1'b1);
    din = 8'h99;
    steps(2);
    expect_val("R8 latched before", int'(dac_code), 8'h6C);
    clr_n = 1'b0;
    steps(2);
    clr_n = 1'b1;
    steps(4);
    expect_val("R8 zero persists", int'(dac_code), 0);
    // converter load alone must bring the cleared staging zero
    strobes(1'b1, 1'b0, 1'b0, 1'b1);
    steps(2);
    expect_val("R8 staging also cleared", int'(dac_code), 0);

    // R10: scaling table at two reference levels
    phase = "R10";
    for (int r = 0; r < 2; r++) begin
      ref_code = (r == 0) ? 8'hFF : 8'h80;
      strobes(1'b0, 1'b0, 1'b0, 1'b1);
      din = 8'hFF; steps(2);
      expect_val("R10 code FF", int'(out_scaled), 255 * int'(ref_code));
      din = 8'h80; steps(2);
      expect_val("R10 code 80", int'(out_scaled), 128 * int'(ref_code));
      din = 8'h01; steps(2);
      expect_val("R10 code 01", int'(out_scaled), int'(ref_code));
      din = 8'h00; steps(2);
      expect_val("R10 code 00", int'(out_scaled), 0);
    end
    ref_code = 8'hFF;
    din = 8'h80; steps(2);
    expect_val("R10 half scale upper byte", int'(out_scaled[15:8]), 8'h7F);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule